// File: doc/BRIEF.md
# Cascaded Wide Binary Counter Chain

This block builds one wide synchronous up-counter out of a parameterized number of 8-bit stages that share one clock, one preset bus and one asynchronous reset. Each stage raises a local active-low terminal-count flag whenever its own byte is all ones. A stage above the lowest one may advance only when the global count enable is active and the OR of the terminal-count flags of every lower stage is low. On the edge that carries into an upper stage, the lower stages roll over to zero. This returns the upper stage to hold on the next cycle.

A global active-low load copies the preset bus into every stage. In divider mode, the chain watches the combined terminal count of all stages. When every stage is at all ones while counting is enabled, the next edge reloads the whole chain from the preset. Presetting the chain to 2^W minus N makes the chain-wide terminal count pulse low for one clock in every N clocks.

Each stage picks one operation per cycle: LOAD, HOLD or COUNT. The transitions are chosen as follows:
- LOAD is taken whenever the stage's load strobe is low, from either of the other two operations.
- COUNT is taken when the stage is enabled and not loading.
- HOLD is taken otherwise.
The reload in divider mode is the LOAD transition, driven by the chain-wide terminal count.

Top module: `wctr_chain`

## Requirements
- R1: Asserting `rst_n` low clears `count` to zero and drives `tc_n` high at once, with no clock edge needed.
- R2: While `load_n` is low, the next rising edge copies `preset` into `count`. This happens whatever the values of `cnt_en_n` and `div_mode`.
- R3: While `load_n` and `cnt_en_n` are both high, `count` keeps its value and `preset` has no effect. This includes the all-ones count in divider mode.
- R4: While `load_n` is high and `cnt_en_n` is low, each rising edge adds one to `count`. A carry crosses every 8-bit stage boundary in the same edge: a stage advances only when every stage below it is all ones.
- R5: With `div_mode` low and counting enabled, an all-ones `count` wraps to zero on the next edge.
- R6: `tc_n` is low exactly when `count` is all ones and `cnt_en_n` is low. Otherwise it is high.
- R7: With `div_mode` high, `load_n` high and `tc_n` low, the next edge loads `preset` into `count` instead of wrapping.
- R8: In divider mode with preset 2^W−N and counting enabled, `tc_n` is low for one cycle in every N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Parallel load of `preset`, active low |
| cnt_en_n | input | 1 | Global count enable, active low |
| div_mode | input | 1 | 1 = reload the chain from `preset` at chain terminal count |
| preset | input | 8*STAGES | Parallel preset value |
| count | output | 8*STAGES | Full chain count |
| tc_n | output | 1 | Chain terminal count, active low |

## Verification
On every cycle, the assertions check the following:
- a stage loads, holds or steps its byte as its local strobes command;
- the whole chain advances by exactly one when enabled below all ones;
- the chain wraps to zero, or reloads from the preset in divider mode, at all ones;
- the terminal count agrees with the count and the enable.

Only the bench's scenarios can show certain behaviours. These are the reset that acts with no clock edge, carries across each particular stage boundary, and the period of the divided output over many cycles. The bench also shows that a changing preset leaves a held count untouched.

// File: rtl/wctr_pkg.sv
package wctr_pkg;
    localparam int STAGE_W = 8;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } stage_op_e;
endpackage

// File: rtl/wctr_stage.sv
module wctr_stage
    import wctr_pkg::*;
#(
    parameter int W = STAGE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pe_n,
    input  logic         ce_n,
    input  logic [W-1:0] pre,
    output logic [W-1:0] q,
    output logic         tc_n
);
    stage_op_e op;

    // operation select: load wins, then the enable decides
    always_comb begin
        if (!pe_n)
            op = OP_LOAD;
        else if (ce_n)
            op = OP_HOLD;
        else
            op = OP_COUNT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  q <= pre;
                OP_COUNT: q <= q + W'(1);
                OP_HOLD:  q <= q;
                default:  q <= q;
            endcase
        end
    end

    // local terminal count: this byte is all ones
    assign tc_n = ~(&q);

    p_stage_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_n |=> q == $past(pre));

    p_stage_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_n && ce_n) |=> q == $past(q));

    p_stage_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_n && !ce_n) |=> q == W'($past(q) + W'(1)));
endmodule

// File: rtl/wctr_link.sv
module wctr_link #(
    parameter int STAGES = 4
) (
    input  logic              cnt_en_n,
    input  logic              load_n,
    input  logic              div_mode,
    input  logic [STAGES-1:0] stage_tc_n,
    output logic [STAGES-1:0] stage_ce_n,
    output logic              pe_n,
    output logic              chain_tc_n
);
    // enable of each stage: global enable ORed with every lower terminal count
    for (genvar i = 0; i < STAGES; i++) begin : g_en
        if (i == 0) begin : g_lsb
            assign stage_ce_n[i] = cnt_en_n;
        end else begin : g_upper
            assign stage_ce_n[i] = cnt_en_n | (|stage_tc_n[i-1:0]);
        end
    end

    // chain terminal count combines every stage, separately from the enables
    assign chain_tc_n = cnt_en_n | (|stage_tc_n);

    // shared load strobe: external load, or reload at chain terminal count in divider mode
    assign pe_n = load_n & ~(div_mode & ~chain_tc_n);
endmodule

// File: rtl/wctr_chain.sv
module wctr_chain
    import wctr_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_n,
    input  logic                      cnt_en_n,
    input  logic                      div_mode,
    input  logic [STAGE_W*STAGES-1:0] preset,
    output logic [STAGE_W*STAGES-1:0] count,
    output logic                      tc_n
);
    localparam int TOTAL_W = STAGE_W * STAGES;

    logic [STAGES-1:0] stage_tc_n;
    logic [STAGES-1:0] stage_ce_n;
    logic              pe_n;

    wctr_link #(.STAGES(STAGES)) u_link (
        .cnt_en_n   (cnt_en_n),
        .load_n     (load_n),
        .div_mode   (div_mode),
        .stage_tc_n (stage_tc_n),
        .stage_ce_n (stage_ce_n),
        .pe_n       (pe_n),
        .chain_tc_n (tc_n)
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        wctr_stage #(.W(STAGE_W)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .pe_n  (pe_n),
            .ce_n  (stage_ce_n[i]),
            .pre   (preset[i*STAGE_W +: STAGE_W]),
            .q     (count[i*STAGE_W +: STAGE_W]),
            .tc_n  (stage_tc_n[i])
        );
    end

    p_chain_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && count != '1) |=> count == TOTAL_W'($past(count) + TOTAL_W'(1)));

    p_chain_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !div_mode && !cnt_en_n && count == '1) |=> count == '0);

    p_chain_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tc_n) == (count == '1 && !cnt_en_n));

    p_chain_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && div_mode && !tc_n) |=> count == $past(preset));

    p_chain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_n) |=> $stable(count));
endmodule

// File: tb/wctr_chain_tb.sv
module wctr_chain_tb;
    localparam int STAGES = 4;
    localparam int TW = 8 * STAGES;

    typedef struct packed {
        logic          ld_n;
        logic          en_n;
        logic          div;
        logic [TW-1:0] pre;
        logic [7:0]    n;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{1'b0, 1'b0, 1'b0, 32'h0000_00FD, 8'd1},
        '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 8'd6},
        '{1'b0, 1'b1, 1'b0, 32'h0000_FFFE, 8'd1},
        '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 8'd4},
        '{1'b0, 1'b0, 1'b0, 32'h00FF_FFFE, 8'd1},
        '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 8'd4},
        '{1'b0, 1'b0, 1'b1, 32'hFFFF_FFFD, 8'd1},
        '{1'b1, 1'b1, 1'b0, 32'h1234_5678, 8'd3},
        '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 8'd5},
        '{1'b0, 1'b0, 1'b0, 32'hFFFF_FFFE, 8'd1},
        '{1'b1, 1'b0, 1'b1, 32'hFFFF_FFF0, 8'd10},
        '{1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 8'd1},
        '{1'b1, 1'b1, 1'b1, 32'h0000_0005, 8'd3},
        '{1'b1, 1'b0, 1'b1, 32'h0000_0005, 8'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_n = 1'b1;
    logic          cnt_en_n = 1'b1;
    logic          div_mode = 1'b0;
    logic [TW-1:0] preset = '0;
    logic [TW-1:0] count;
    logic          tc_n;

    logic [TW-1:0] ref_cnt = '0;
    int            n_checks = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    wctr_chain #(.STAGES(STAGES)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .cnt_en_n (cnt_en_n),
        .div_mode (div_mode),
        .preset   (preset),
        .count    (count),
        .tc_n     (tc_n)
    );

    task automatic check(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock of stimulus: starts and ends at a falling edge
    task automatic step(input logic ld, input logic en, input logic dv, input logic [TW-1:0] pv);
        string tag;
        logic  exp_tc;
        load_n = ld; cnt_en_n = en; div_mode = dv; preset = pv;
        #1;
        exp_tc = !((ref_cnt == '1) && !en);
        check("R6", {{(TW-1){1'b0}}, tc_n}, {{(TW-1){1'b0}}, exp_tc});
        if (!ld) begin
            tag = "R2"; ref_cnt = pv;
        end else if (en) begin
            tag = "R3";
        end else if (ref_cnt == '1) begin
            if (dv) begin tag = "R7"; ref_cnt = pv; end
            else    begin tag = "R5"; ref_cnt = '0; end
        end else begin
            tag = "R4"; ref_cnt = ref_cnt + 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, count, ref_cnt);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        int lows;
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1", count, '0);
        check("R1", {{(TW-1){1'b0}}, tc_n}, {{(TW-1){1'b0}}, 1'b1});
        rst_n = 1'b1;
        ref_cnt = '0;

        for (int v = 0; v < 14; v++) begin
            for (int c = 0; c < int'(VECS[v].n); c++) begin
                step(VECS[v].ld_n, VECS[v].en_n, VECS[v].div, VECS[v].pre);
            end
        end

        // R8: divide by 7 with preset 2^32-7
        step(1'b0, 1'b0, 1'b1, 32'hFFFF_FFF9);
        lows = 0;
        for (int c = 0; c < 21; c++) begin
            step(1'b1, 1'b0, 1'b1, 32'hFFFF_FFF9);
            #1;
            if (!tc_n) lows++;
        end
        check("R8", TW'(lows), TW'(3));

        // R1: asynchronous reset between clock edges
        step(1'b0, 1'b1, 1'b0, 32'hA5A5_5A5A);
        #2;
        rst_n = 1'b0;
        #1;
        check("R1", count, '0);
        check("R1", {{(TW-1){1'b0}}, tc_n}, {{(TW-1){1'b0}}, 1'b1});
        @(negedge clk);
        rst_n = 1'b1;
        ref_cnt = '0;
        step(1'b1, 1'b0, 1'b0, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule